// File: doc/BRIEF.md
# Gapped Memory Map Address Decoder

This block sits between the bus of a small 8-bit processor (16-bit address, 8-bit data) and its peripherals. Each read or write strobe is classified against a fixed memory map with holes: a 32 KiB RAM region at the bottom, a 16 KiB ROM region at the top, and three small windows between them for general-purpose I/O, a sound controller and a video controller. The block then raises one registered chip-select for that access. With it, the block passes on the offset inside the region and the write data. A separate pin moves the access into an isolated port space, which never touches the memory regions and carries a transfer length of 1, 2 or 4 bytes.

Read data is taken from the device that decodes the current address and is registered, so it is valid exactly one clock after the strobe. Addresses that fall in a hole return 0xFF and pulse an unmapped flag. A build-time parameter selects one of two decoders. The exhaustive decoder compares every address line. The partial decoder compares only a few upper lines, which makes each register appear at several aliased addresses. A small register bank stands in for the video controller so that its background-colour register can be observed.

Top module: `addr_fabric`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises with no strobe, every select, io_stb, dev_we, rd_valid and unmapped is 0, io_port, io_bytes and dev_ofs are 0, rd_data is 0xFF and bg_colour is 0.
- R2: With exhaustive decoding, a memory access raises exactly one select one cycle after the strobe: sel_ram for 0x0000–0x7FFF, sel_gpio for 0x8000–0x80FF, sel_snd for 0x9000–0x90FF, sel_vid for 0xA000–0xA7FF, sel_rom for 0xC000–0xFFFF.
- R3: With exhaustive decoding, an access to any other address raises no select and no dev_we, and pulses unmapped for one cycle. A read there returns 0xFF. A write there changes no video register, so bg_colour is unchanged.
- R4: With partial decoding, only address bits [15:12] are compared. Bit 15 low selects RAM, bits [15:14] = 11 select ROM, bits [15:12] = 1000 select GPIO, 1001 select sound, and bits [15:13] = 101 select video. An alias such as 0x8F05 or 0xB803 reaches the same register as 0x8005 or 0xA003, and unmapped never pulses.
- R5: dev_ofs carries the low address bits, masked to the region size: 15 bits for RAM, 14 for ROM, 11 for video, 8 for GPIO and sound. dev_ofs is 0 for port accesses and for idle cycles.
- R6: When cpu_io is high, no memory select is raised. io_stb pulses, io_port equals the full 16-bit address, and io_bytes is 1, 2 or 4 for cpu_size 0, 1 or 2. cpu_size 3 gives 1. A read returns port_rdata.
- R7: rd_valid is high exactly in the cycle after a read strobe and at no other time. rd_data then holds the selected device's byte. For video, that byte is stub register address[2:0].
- R8: A write to video offset 3 (0xA003) loads bg_colour on the same edge that raises sel_vid. The value can be read back at the same offset.
- R9: Every write strobe to a mapped address gives exactly one dev_we cycle, one clock later, carrying its own data. Back-to-back writes come out in issue order and are never merged.
- R10: If cpu_rd and cpu_wr are both high, the access is a write. No read is started and rd_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_io | input | 1 | High selects the isolated port space |
| cpu_size | input | 2 | Port transfer length code (0:1, 1:2, 2:4, 3:1 byte) |
| ram_rdata | input | 8 | RAM byte for the current address |
| gpio_rdata | input | 8 | GPIO byte for the current address |
| snd_rdata | input | 8 | Sound controller byte for the current address |
| rom_rdata | input | 8 | ROM byte for the current address |
| port_rdata | input | 8 | Port-space byte for the current address |
| sel_ram | output | 1 | RAM chip-select |
| sel_gpio | output | 1 | GPIO chip-select |
| sel_snd | output | 1 | Sound controller chip-select |
| sel_vid | output | 1 | Video controller chip-select |
| sel_rom | output | 1 | ROM chip-select |
| io_stb | output | 1 | Port-space access strobe |
| io_port | output | 16 | Port number |
| io_bytes | output | 3 | Port transfer length in bytes |
| dev_ofs | output | 15 | Offset inside the selected region |
| dev_wdata | output | 8 | Write data to the device |
| dev_we | output | 1 | Write enable for the selected device or port |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| unmapped | output | 1 | Access hit a hole in the map |
| bg_colour | output | 8 | Video stub background-colour register |

## Verification
Every result of this block is due one clock after the strobe that causes it. This covers the selects, offset, write data, port fields, the unmapped pulse and read data. The only exception is bg_colour, which changes on that same edge. The driver applies a strobe on a falling edge and computes the expected outputs for both decoder variants. It queues them on the next rising edge, and the monitor compares them on the falling edge after that. As a result, each queued item is checked in exactly the cycle the result is due. Idle cycles are queued too, so a select or rd_valid that arrives late, early or twice is caught. The background colour is read straight off its port on the falling edge after the write.

// File: rtl/addr_fabric_pkg.sv
// Package: shared widths, region codes and idle byte for the decoder fabric.
// Assumes a 16-bit byte address and an 8-bit data path.
package addr_fabric_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 15;
    localparam int NBYT_W = 3;

    localparam logic [DATA_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_RAM,
        RGN_GPIO,
        RGN_SND,
        RGN_VID,
        RGN_ROM,
        RGN_PORT
    } region_e;

    // Offset mask that keeps only the lines inside a region.
    function automatic logic [OFS_W-1:0] region_mask(region_e rgn);
        case (rgn)
            RGN_RAM:           return 15'h7FFF;
            RGN_ROM:           return 15'h3FFF;
            RGN_VID:           return 15'h07FF;
            RGN_GPIO, RGN_SND: return 15'h00FF;
            default:           return '0;
        endcase
    endfunction
endpackage

// File: rtl/addr_region_dec.sv
// Module: combinational region classifier.
// FULL_DECODE=1 compares every upper line, so the map keeps its holes.
// FULL_DECODE=0 compares bits [15:12] only, so regions alias and fill the holes.
// Assumes the port-space pin overrides every memory region.
module addr_region_dec
    import addr_fabric_pkg::*;
#(
    parameter bit FULL_DECODE = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_space,
    output region_e           rgn,
    output logic [OFS_W-1:0]  ofs
);
    region_e mem_rgn;

    generate
        if (FULL_DECODE) begin : g_full
            // Exhaustive compare of all lines above each region's offset field.
            always_comb begin
                if (!addr[15])                 mem_rgn = RGN_RAM;
                else if (addr[15:14] == 2'b11) mem_rgn = RGN_ROM;
                else if (addr[15:8] == 8'h80)  mem_rgn = RGN_GPIO;
                else if (addr[15:8] == 8'h90)  mem_rgn = RGN_SND;
                else if (addr[15:11] == 5'b10100) mem_rgn = RGN_VID;
                else                           mem_rgn = RGN_NONE;
            end
        end else begin : g_partial
            // Cheap compare of the top nibble only; lower lines fold back.
            always_comb begin
                if (!addr[15])                   mem_rgn = RGN_RAM;
                else if (addr[15:14] == 2'b11)   mem_rgn = RGN_ROM;
                else if (addr[15:12] == 4'b1000) mem_rgn = RGN_GPIO;
                else if (addr[15:12] == 4'b1001) mem_rgn = RGN_SND;
                else                             mem_rgn = RGN_VID;
            end
        end
    endgenerate

    // Port space wins; offset is the masked low lines of the address.
    always_comb begin
        rgn = io_space ? RGN_PORT : mem_rgn;
        ofs = addr[OFS_W-1:0] & region_mask(rgn);
    end
endmodule

// File: rtl/addr_rdata_mux.sv
// Module: read-data steering, picks the byte of the region being accessed.
// Assumes each device presents its byte combinationally for the current address.
module addr_rdata_mux
    import addr_fabric_pkg::*;
(
    input  region_e           rgn,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] gpio_rdata,
    input  logic [DATA_W-1:0] snd_rdata,
    input  logic [DATA_W-1:0] vid_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] port_rdata,
    output logic [DATA_W-1:0] rdata
);
    // One-level case mux; holes return the idle byte.
    always_comb begin
        case (rgn)
            RGN_RAM:  rdata = ram_rdata;
            RGN_GPIO: rdata = gpio_rdata;
            RGN_SND:  rdata = snd_rdata;
            RGN_VID:  rdata = vid_rdata;
            RGN_ROM:  rdata = rom_rdata;
            RGN_PORT: rdata = port_rdata;
            default:  rdata = IDLE_BYTE;
        endcase
    end
endmodule

// File: rtl/vid_stub_regs.sv
// Module: test stand-in for the video controller register bank.
// Register BG_INDEX drives the background colour. NREGS is a power of two and
// folds over the whole video window.
module vid_stub_regs
    import addr_fabric_pkg::*;
#(
    parameter int NREGS    = 8,
    parameter int BG_INDEX = 3,
    parameter int IDX_W    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bg
);
    logic [DATA_W-1:0] regs [NREGS];

    // Register file: cleared by reset, one byte written per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[idx] <= wdata;
        end
    end

    assign rdata = regs[idx];
    assign bg    = regs[BG_INDEX];
endmodule

// File: rtl/addr_fabric.sv
// Module: top of the address decoder fabric.
// Registers one chip-select, offset, write data and read byte per strobe.
// Assumes strobes are single-cycle, and that a write wins when both strobes are high.
module addr_fabric
    import addr_fabric_pkg::*;
#(
    parameter bit FULL_DECODE = 1'b1,
    parameter int VID_REGS    = 8,
    parameter int BG_INDEX    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_io,
    input  logic [1:0]        cpu_size,
    input  logic [7:0]        ram_rdata,
    input  logic [7:0]        gpio_rdata,
    input  logic [7:0]        snd_rdata,
    input  logic [7:0]        rom_rdata,
    input  logic [7:0]        port_rdata,
    output logic              sel_ram,
    output logic              sel_gpio,
    output logic              sel_snd,
    output logic              sel_vid,
    output logic              sel_rom,
    output logic              io_stb,
    output logic [15:0]       io_port,
    output logic [2:0]        io_bytes,
    output logic [14:0]       dev_ofs,
    output logic [7:0]        dev_wdata,
    output logic              dev_we,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              unmapped,
    output logic [7:0]        bg_colour
);
    localparam int VID_IDX_W = $clog2(VID_REGS);

    region_e           rgn_c;
    logic [OFS_W-1:0]  ofs_c;
    logic [DATA_W-1:0] vid_rd_c;
    logic [DATA_W-1:0] mux_c;
    logic [NBYT_W-1:0] nbytes_c;
    logic              acc_c, wr_c, rd_c, hit_c, vid_we_c;

    addr_region_dec #(.FULL_DECODE(FULL_DECODE)) u_dec (
        .addr     (cpu_addr),
        .io_space (cpu_io),
        .rgn      (rgn_c),
        .ofs      (ofs_c)
    );

    // Strobe qualification: write has priority over read.
    always_comb begin
        wr_c     = cpu_wr;
        rd_c     = cpu_rd & ~cpu_wr;
        acc_c    = cpu_rd | cpu_wr;
        hit_c    = (rgn_c != RGN_NONE);
        vid_we_c = wr_c && (rgn_c == RGN_VID);
    end

    // Port length code to byte count; the spare code falls back to one byte.
    always_comb begin
        case (cpu_size)
            2'd1:    nbytes_c = 3'd2;
            2'd2:    nbytes_c = 3'd4;
            default: nbytes_c = 3'd1;
        endcase
    end

    vid_stub_regs #(.NREGS(VID_REGS), .BG_INDEX(BG_INDEX)) u_vid (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vid_we_c),
        .idx   (ofs_c[VID_IDX_W-1:0]),
        .wdata (cpu_wdata),
        .rdata (vid_rd_c),
        .bg    (bg_colour)
    );

    addr_rdata_mux u_mux (
        .rgn        (rgn_c),
        .ram_rdata  (ram_rdata),
        .gpio_rdata (gpio_rdata),
        .snd_rdata  (snd_rdata),
        .vid_rdata  (vid_rd_c),
        .rom_rdata  (rom_rdata),
        .port_rdata (port_rdata),
        .rdata      (mux_c)
    );

    // Output register stage: one device cycle per strobe, in issue order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ram   <= 1'b0;
            sel_gpio  <= 1'b0;
            sel_snd   <= 1'b0;
            sel_vid   <= 1'b0;
            sel_rom   <= 1'b0;
            io_stb    <= 1'b0;
            io_port   <= '0;
            io_bytes  <= '0;
            dev_ofs   <= '0;
            dev_wdata <= '0;
            dev_we    <= 1'b0;
            rd_valid  <= 1'b0;
            unmapped  <= 1'b0;
            rd_data   <= IDLE_BYTE;
        end else begin
            sel_ram   <= acc_c && (rgn_c == RGN_RAM);
            sel_gpio  <= acc_c && (rgn_c == RGN_GPIO);
            sel_snd   <= acc_c && (rgn_c == RGN_SND);
            sel_vid   <= acc_c && (rgn_c == RGN_VID);
            sel_rom   <= acc_c && (rgn_c == RGN_ROM);
            io_stb    <= acc_c && (rgn_c == RGN_PORT);
            io_port   <= (acc_c && rgn_c == RGN_PORT) ? cpu_addr : '0;
            io_bytes  <= (acc_c && rgn_c == RGN_PORT) ? nbytes_c : '0;
            dev_ofs   <= acc_c ? ofs_c : '0;
            dev_wdata <= wr_c ? cpu_wdata : '0;
            dev_we    <= wr_c && hit_c;
            rd_valid  <= rd_c;
            unmapped  <= acc_c && !hit_c;
            if (rd_c) rd_data <= mux_c;
        end
    end
endmodule

// File: rtl/addr_fabric_chk.sv
// Module: property checker for addr_fabric, attached to every instance by bind.
// Assumes the video background register sits at offset 3.
module addr_fabric_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_wdata,
    input logic        sel_ram,
    input logic        sel_gpio,
    input logic        sel_snd,
    input logic        sel_vid,
    input logic        sel_rom,
    input logic        io_stb,
    input logic [2:0]  io_bytes,
    input logic [14:0] dev_ofs,
    input logic [7:0]  dev_wdata,
    input logic        dev_we,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input logic        unmapped,
    input logic [7:0]  bg_colour
);
    // R2: at most one target per cycle.
    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_gpio, sel_snd, sel_vid, sel_rom, io_stb}));

    // R3: a hole reaches no device.
    assert_gap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> !(sel_ram || sel_gpio || sel_snd || sel_vid || sel_rom || io_stb || dev_we));

    // R3: a hole reads as the idle byte.
    assert_gap_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unmapped && rd_valid) |-> rd_data == 8'hFF);

    // R5: small windows carry only eight offset bits.
    assert_ofs_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_gpio || sel_snd) |-> dev_ofs[14:8] == 7'd0);

    // R6: port transfers are 1, 2 or 4 bytes and carry no offset.
    assert_port_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_stb |-> ($countones(io_bytes) == 1 && !io_bytes[2:0][0] == (io_bytes != 3'd1) && dev_ofs == 15'd0));

    // R7 and R10: valid exactly one cycle after a read that is not also a write.
    assert_rd_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_valid == $past(cpu_rd && !cpu_wr));

    // R8: the background register follows a write to offset 3.
    assert_bg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vid && dev_we && dev_ofs[2:0] == 3'd3) |-> bg_colour == dev_wdata);

    // R9: each mapped write comes out on the next cycle with its own data.
    assert_wr_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_wr) && !unmapped) |-> (dev_we && dev_wdata == $past(cpu_wdata)));
endmodule

bind addr_fabric addr_fabric_chk u_chk (.*);

// File: tb/addr_fabric_test.sv
// Bench: scoreboard for both decoder variants. The driver queues the expected
// outputs for each cycle, and the monitor compares them one falling edge later.
`timescale 1ns/1ps
module addr_fabric_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_io = 1'b0;
    logic [1:0]  cpu_size = '0;
    logic [7:0]  ram_rd, gpio_rd, snd_rd, rom_rd, port_rd;

    assign ram_rd  = cpu_addr[7:0] ^ 8'h11;
    assign gpio_rd = cpu_addr[7:0] ^ 8'h22;
    assign snd_rd  = cpu_addr[7:0] ^ 8'h33;
    assign rom_rd  = cpu_addr[7:0] ^ 8'h44;
    assign port_rd = cpu_addr[7:0] ^ 8'h55;

    always #4 clk = ~clk;

    logic        f_ram, f_gpio, f_snd, f_vid, f_rom, f_io, f_we, f_rv, f_unm;
    logic [15:0] f_port; logic [2:0] f_nb; logic [14:0] f_ofs;
    logic [7:0]  f_wd, f_rdat, f_bg;
    logic        p_ram, p_gpio, p_snd, p_vid, p_rom, p_io, p_we, p_rv, p_unm;
    logic [15:0] p_port; logic [2:0] p_nb; logic [14:0] p_ofs;
    logic [7:0]  p_wd, p_rdat, p_bg;

    addr_fabric #(.FULL_DECODE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_io(cpu_io), .cpu_size(cpu_size),
        .ram_rdata(ram_rd), .gpio_rdata(gpio_rd), .snd_rdata(snd_rd),
        .rom_rdata(rom_rd), .port_rdata(port_rd),
        .sel_ram(f_ram), .sel_gpio(f_gpio), .sel_snd(f_snd), .sel_vid(f_vid),
        .sel_rom(f_rom), .io_stb(f_io), .io_port(f_port), .io_bytes(f_nb),
        .dev_ofs(f_ofs), .dev_wdata(f_wd), .dev_we(f_we), .rd_data(f_rdat),
        .rd_valid(f_rv), .unmapped(f_unm), .bg_colour(f_bg));

    addr_fabric #(.FULL_DECODE(1'b0)) uut_alias (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_io(cpu_io), .cpu_size(cpu_size),
        .ram_rdata(ram_rd), .gpio_rdata(gpio_rd), .snd_rdata(snd_rd),
        .rom_rdata(rom_rd), .port_rdata(port_rd),
        .sel_ram(p_ram), .sel_gpio(p_gpio), .sel_snd(p_snd), .sel_vid(p_vid),
        .sel_rom(p_rom), .io_stb(p_io), .io_port(p_port), .io_bytes(p_nb),
        .dev_ofs(p_ofs), .dev_wdata(p_wd), .dev_we(p_we), .rd_data(p_rdat),
        .rd_valid(p_rv), .unmapped(p_unm), .bg_colour(p_bg));

    typedef struct packed {
        logic [5:0]  sel;    // {io, rom, vid, snd, gpio, ram}
        logic [14:0] ofs;
        logic        we;
        logic [7:0]  wd;
        logic        rv;
        logic [7:0]  rdat;
        logic        unm;
        logic [15:0] port;
        logic [2:0]  nb;
    } exp_t;

    exp_t  q_f[$];
    exp_t  q_p[$];
    string q_tag[$];
    logic [7:0] vm_f [8];
    logic [7:0] vm_p [8];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Region code from the requirements: 0 hole, 1 ram, 2 gpio, 3 snd, 4 vid, 5 rom, 6 port.
    function automatic int region_of(bit full, logic io, logic [15:0] a);
        if (io) return 6;
        if (!a[15]) return 1;
        if (a[15:14] == 2'b11) return 5;
        if (full) begin
            if (a[15:8] == 8'h80) return 2;
            if (a[15:8] == 8'h90) return 3;
            if (a[15:11] == 5'b10100) return 4;
            return 0;
        end
        if (a[15:12] == 4'h8) return 2;
        if (a[15:12] == 4'h9) return 3;
        return 4;
    endfunction

    function automatic exp_t model(bit full, logic io, logic rd, logic wr, logic [15:0] a,
                                   logic [7:0] d, logic [1:0] sz, logic [7:0] vreg);
        exp_t e = '0;
        int r = region_of(full, io, a);
        logic acc = rd | wr;
        if (acc && r != 0) e.sel = 6'(1 << (r - 1));
        if (acc) begin
            case (r)
                1: e.ofs = a[14:0];
                5: e.ofs = {1'b0, a[13:0]};
                4: e.ofs = {4'b0, a[10:0]};
                2, 3: e.ofs = {7'b0, a[7:0]};
                default: e.ofs = '0;
            endcase
        end
        e.we = wr && r != 0;
        e.wd = d;
        e.rv = rd && !wr;
        case (r)
            1: e.rdat = a[7:0] ^ 8'h11;
            2: e.rdat = a[7:0] ^ 8'h22;
            3: e.rdat = a[7:0] ^ 8'h33;
            4: e.rdat = vreg;
            5: e.rdat = a[7:0] ^ 8'h44;
            6: e.rdat = a[7:0] ^ 8'h55;
            default: e.rdat = 8'hFF;
        endcase
        e.unm = acc && r == 0;
        if (acc && io) begin
            e.port = a;
            e.nb = (sz == 2'd1) ? 3'd2 : (sz == 2'd2) ? 3'd4 : 3'd1;
        end
        return e;
    endfunction

    // Driver: apply one cycle of stimulus, queue what is due one clock later.
    task automatic drive(input string tag, input logic io, input logic rd, input logic wr,
                         input logic [15:0] a, input logic [7:0] d, input logic [1:0] sz);
        exp_t ef, ep;
        @(negedge clk);
        cpu_io = io; cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; cpu_size = sz;
        ef = model(1'b1, io, rd, wr, a, d, sz, vm_f[a[2:0]]);
        ep = model(1'b0, io, rd, wr, a, d, sz, vm_p[a[2:0]]);
        if (wr && region_of(1'b1, io, a) == 4) vm_f[a[2:0]] = d;
        if (wr && region_of(1'b0, io, a) == 4) vm_p[a[2:0]] = d;
        @(posedge clk);
        q_f.push_back(ef); q_p.push_back(ep); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive("idle R7", 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 2'd0);
    endtask

    task automatic cmp(input string tag, input string who, input exp_t e,
                       input logic [5:0] sel, input logic [14:0] ofs, input logic we,
                       input logic [7:0] wd, input logic rv, input logic [7:0] rdat,
                       input logic unm, input logic [15:0] port, input logic [2:0] nb);
        chk(tag, {who, " selects"}, 32'(sel), 32'(e.sel));
        chk(tag, {who, " dev_ofs"}, 32'(ofs), 32'(e.ofs));
        chk(tag, {who, " dev_we"}, 32'(we), 32'(e.we));
        if (e.we) chk(tag, {who, " dev_wdata"}, 32'(wd), 32'(e.wd));
        chk(tag, {who, " rd_valid"}, 32'(rv), 32'(e.rv));
        if (e.rv) chk(tag, {who, " rd_data"}, 32'(rdat), 32'(e.rdat));
        chk(tag, {who, " unmapped"}, 32'(unm), 32'(e.unm));
        chk(tag, {who, " io_port"}, 32'(port), 32'(e.port));
        chk(tag, {who, " io_bytes"}, 32'(nb), 32'(e.nb));
    endtask

    // Monitor: one queued item per cycle, compared away from the rising edge.
    always @(negedge clk) begin
        if (q_tag.size() > 0) begin
            exp_t ef, ep;
            string tg;
            ef = q_f.pop_front(); ep = q_p.pop_front(); tg = q_tag.pop_front();
            cmp(tg, "full", ef, {f_io, f_rom, f_vid, f_snd, f_gpio, f_ram}, f_ofs, f_we, f_wd,
                f_rv, f_rdat, f_unm, f_port, f_nb);
            cmp(tg, "alias", ep, {p_io, p_rom, p_vid, p_snd, p_gpio, p_ram}, p_ofs, p_we, p_wd,
                p_rv, p_rdat, p_unm, p_port, p_nb);
        end
    end

    task automatic check_bg(input string req);
        @(negedge clk);
        chk(req, "full bg_colour", 32'(f_bg), 32'(vm_f[3]));
        chk(req, "alias bg_colour", 32'(p_bg), 32'(vm_p[3]));
    endtask

    task automatic check_reset(input string tag);
        chk(tag, "full idle outputs", 32'({f_ram, f_gpio, f_snd, f_vid, f_rom, f_io, f_we, f_rv, f_unm}), 32'd0);
        chk(tag, "alias idle outputs", 32'({p_ram, p_gpio, p_snd, p_vid, p_rom, p_io, p_we, p_rv, p_unm}), 32'd0);
        chk(tag, "full port fields", 32'({f_port, f_nb, f_ofs}), 32'd0);
        chk(tag, "full rd_data", 32'(f_rdat), 32'hFF);
        chk(tag, "alias rd_data", 32'(p_rdat), 32'hFF);
        chk(tag, "bg_colour", 32'({f_bg, p_bg}), 32'd0);
    endtask

    function automatic void summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) begin vm_f[i] = '0; vm_p[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("R1 after release");

        // R2 / R7: each region read at its edges.
        drive("R2 ram low", 0, 1, 0, 16'h1234, 8'h00, 2'd0);
        drive("R2 ram top", 0, 1, 0, 16'h7FFF, 8'h00, 2'd0);
        drive("R7 back-to-back read", 0, 1, 0, 16'h7FFF, 8'h00, 2'd0);
        drive("R2 gpio", 0, 1, 0, 16'h8005, 8'h00, 2'd0);
        drive("R2 sound", 0, 1, 0, 16'h90AB, 8'h00, 2'd0);
        drive("R2 rom base", 0, 1, 0, 16'hC000, 8'h00, 2'd0);
        drive("R5 rom top", 0, 1, 0, 16'hFFFF, 8'h00, 2'd0);
        drive("R5 video top", 0, 1, 0, 16'hA7FE, 8'h00, 2'd0);
        idle(2);

        // R3 / R4: holes versus aliases.
        drive("R3 R4 gpio hole read", 0, 1, 0, 16'h8100, 8'h00, 2'd0);
        drive("R3 R4 gpio alias read", 0, 1, 0, 16'h8F05, 8'h00, 2'd0);
        drive("R3 R4 vid hole write", 0, 0, 1, 16'hA800, 8'h77, 2'd0);
        drive("R8 bg write", 0, 0, 1, 16'hA003, 8'h3C, 2'd0);
        check_bg("R8");
        drive("R3 R4 vid alias write", 0, 0, 1, 16'hB803, 8'h99, 2'd0);
        check_bg("R3 R4 bg after alias");
        drive("R8 readback", 0, 1, 0, 16'hA003, 8'h00, 2'd0);
        drive("R4 alias read B000", 0, 1, 0, 16'hB000, 8'h00, 2'd0);
        drive("R3 snd hole read", 0, 1, 0, 16'h9100, 8'h00, 2'd0);
        idle(1);

        // R6: port space, all size codes, including an address that is GPIO in memory.
        drive("R6 port 1 byte", 1, 0, 1, 16'h0060, 8'hA1, 2'd0);
        drive("R6 port 2 bytes", 1, 0, 1, 16'h0061, 8'hA2, 2'd1);
        drive("R6 port 4 bytes", 1, 0, 1, 16'h0062, 8'hA3, 2'd2);
        drive("R6 port spare code", 1, 0, 1, 16'h0063, 8'hA4, 2'd3);
        drive("R6 port read", 1, 1, 0, 16'h80A1, 8'h00, 2'd0);
        idle(1);

        // R9: back-to-back writes keep order and data.
        drive("R9 write 0", 0, 0, 1, 16'h0010, 8'h01, 2'd0);
        drive("R9 write 1", 0, 0, 1, 16'h0010, 8'h02, 2'd0);
        drive("R9 write 2", 0, 0, 1, 16'hA005, 8'h03, 2'd0);
        drive("R9 write 3", 0, 0, 1, 16'h9002, 8'h04, 2'd0);
        drive("R7 read after write", 0, 1, 0, 16'hA005, 8'h00, 2'd0);

        // R10: both strobes high is a write.
        drive("R10 rd+wr", 0, 1, 1, 16'h0100, 8'h5A, 2'd0);
        drive("R10 rd+wr video", 0, 1, 1, 16'hA003, 8'h42, 2'd0);
        check_bg("R10 R8");
        idle(3);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R7: actual hung run expected completion");
            summary();
            $finish;
        end
    end
endmodule